// File: doc/BRIEF.md
# Domain Transgression Filter

The filter sits in front of a global data arbiter. Each board has one request lane, and each lane carries a valid flag, a source board ID, a target board ID and a parity bit. In the cycle a request arrives, the filter compares it with a programmable domain-membership table. A request whose source and target share a domain passes through as a grant. A request that crosses domains is always blocked, so it cannot reach a board outside its own domain. This includes interrupt vectors that software aims at foreign boards.

The filter can optionally report a blocked crossing. A reported crossing raises stop requests on every board in the source's domain. A request with a parity error is also blocked, and it raises a global stop. Stop requests hold until software clears them. The filter also captures the IDs of the first offending request for debug.

The membership table has one mask per board. In the mask owned by board `s`, bit `t` set means board `t` is in the same domain as board `s`. The arbitration that follows this filter is not part of this block.

Top module: `xdom_filter`

## Requirements
- R1: Lane `i` asserts `gnt_valid[i]` in the same cycle as its request exactly when all of these hold:
  - `req_valid[i]` is high;
  - the parity is good;
  - both IDs are below `NB`;
  - bit `tgt` of the source board's mask is set.
- R2: After reset, each board's mask holds only its own bit. A write with `cfg_mask_we` loads `cfg_mask_data` into the mask of board `cfg_mask_sel`, and the owner's own bit is forced to 1. The new mask governs requests from the next cycle on. A write with `cfg_mask_sel` of `NB` or more changes nothing.
- R3: Reporting is disabled after reset, and `cfg_ctl_we` loads `cfg_rpt_en` into the enable. While reporting is disabled, blocked crossings leave `stop_brd` and `dbg_valid` unchanged.
- R4: While reporting is enabled, a blocked crossing with a source ID below `NB` ORs the source board's mask into `stop_brd` on the next clock edge. A blocked request whose source ID is `NB` or more raises no stop and is not captured.
- R5: Parity is even over `{valid, src, tgt, par}`, and it is checked only while `valid` is high. A parity error blocks the request, sets `stop_glob` on the next edge, and leaves `stop_brd` unchanged.
- R6: `stop_brd` and `stop_glob` stay set until `stop_clr` is pulsed. If a new event arrives in the same cycle as the clear, the event's bits are set after that edge.
- R7: The first reported event (a parity error, or a reported crossing) loads `dbg_valid`, `dbg_src` and `dbg_tgt`. When several lanes report in the same cycle, the lowest-numbered lane wins. The capture holds until `stop_clr`.
- R8: All lanes are filtered independently in the same cycle, and their stop contributions are ORed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mask_we | input | 1 | Write strobe for a membership mask |
| cfg_mask_sel | input | IDW | Board whose mask is written |
| cfg_mask_data | input | NB | New membership mask |
| cfg_ctl_we | input | 1 | Write strobe for the report enable |
| cfg_rpt_en | input | 1 | Report enable value |
| stop_clr | input | 1 | Clears stops and the debug capture |
| req_valid | input | NB | Request valid, one bit per lane |
| req_src | input | NB*IDW | Source ID per lane, lane i at [i*IDW +: IDW] |
| req_tgt | input | NB*IDW | Target ID per lane, same packing |
| req_par | input | NB | Parity bit per lane |
| gnt_valid | output | NB | Request passed the filter |
| stop_brd | output | NB | Sticky stop request per board |
| stop_glob | output | 1 | Sticky global stop request |
| dbg_valid | output | 1 | Debug capture holds an event |
| dbg_src | output | IDW | Source ID of the first event |
| dbg_tgt | output | IDW | Target ID of the first event |

## Verification
The bench builds the filter with `NB = 6`, which gives 3-bit IDs. With this setting, IDs 6 and 7 fit in the ID field but name no board, so the out-of-range source and target cases of R1 and R4 can actually be reached. Six lanes are enough to set up three domains of different sizes. They also let the bench put several lanes in one cycle, so it can exercise the lowest-lane priority of R7 together with the ORing of R8.

// File: rtl/xdom_filter.sv
module xdom_filter #(
  parameter int NB = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_mask_we,
  input  logic [((NB>1)?$clog2(NB):1)-1:0] cfg_mask_sel,
  input  logic [NB-1:0]                 cfg_mask_data,
  input  logic                          cfg_ctl_we,
  input  logic                          cfg_rpt_en,
  input  logic                          stop_clr,
  input  logic [NB-1:0]                 req_valid,
  input  logic [NB*((NB>1)?$clog2(NB):1)-1:0] req_src,
  input  logic [NB*((NB>1)?$clog2(NB):1)-1:0] req_tgt,
  input  logic [NB-1:0]                 req_par,
  output logic [NB-1:0]                 gnt_valid,
  output logic [NB-1:0]                 stop_brd,
  output logic                          stop_glob,
  output logic                          dbg_valid,
  output logic [((NB>1)?$clog2(NB):1)-1:0] dbg_src,
  output logic [((NB>1)?$clog2(NB):1)-1:0] dbg_tgt
);
  localparam int IDW = (NB > 1) ? $clog2(NB) : 1;

  logic [NB-1:0]  mask_q [NB];
  logic           rpt_en_q;
  logic [NB-1:0]  perr_v;
  logic [NB-1:0]  ev_v;
  logic [NB-1:0]  set_brd;
  logic           ev_any;
  logic [IDW-1:0] ev_src, ev_tgt;

  for (genvar b = 0; b < NB; b++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        mask_q[b] <= NB'(1) << b;
      else if (cfg_mask_we && int'(cfg_mask_sel) == b)
        mask_q[b] <= cfg_mask_data | (NB'(1) << b);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          rpt_en_q <= 1'b0;
    else if (cfg_ctl_we) rpt_en_q <= cfg_rpt_en;

  always_comb begin
    gnt_valid = '0;
    perr_v    = '0;
    ev_v      = '0;
    set_brd   = '0;
    ev_src    = '0;
    ev_tgt    = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      logic [IDW-1:0] s, t;
      logic [NB-1:0]  smask;
      logic           s_ok, t_ok, member;
      s      = req_src[i*IDW +: IDW];
      t      = req_tgt[i*IDW +: IDW];
      s_ok   = int'(s) < NB;
      t_ok   = int'(t) < NB;
      smask  = s_ok ? mask_q[s] : '0;
      member = s_ok && t_ok && smask[t];
      perr_v[i]    = req_valid[i] && ^{1'b1, s, t, req_par[i]};
      gnt_valid[i] = req_valid[i] && !perr_v[i] && member;
      ev_v[i]      = perr_v[i] ||
                     (rpt_en_q && req_valid[i] && !member && s_ok);
      if (rpt_en_q && req_valid[i] && !perr_v[i] && !member)
        set_brd = set_brd | smask;
      if (ev_v[i]) begin
        ev_src = s;
        ev_tgt = t;
      end
    end
  end

  assign ev_any = |ev_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stop_brd  <= '0;
      stop_glob <= 1'b0;
    end else begin
      stop_brd  <= (stop_clr ? '0 : stop_brd) | set_brd;
      stop_glob <= (stop_clr ? 1'b0 : stop_glob) | (|perr_v);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dbg_valid <= 1'b0;
      dbg_src   <= '0;
      dbg_tgt   <= '0;
    end else if (ev_any && (stop_clr || !dbg_valid)) begin
      dbg_valid <= 1'b1;
      dbg_src   <= ev_src;
      dbg_tgt   <= ev_tgt;
    end else if (stop_clr) begin
      dbg_valid <= 1'b0;
      dbg_src   <= '0;
      dbg_tgt   <= '0;
    end
endmodule

module xdom_filter_chk #(
  parameter int NB = 8
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                stop_clr,
  input logic [NB-1:0]                       req_valid,
  input logic [NB-1:0]                       gnt_valid,
  input logic [NB-1:0]                       stop_brd,
  input logic                                stop_glob,
  input logic                                dbg_valid,
  input logic [((NB>1)?$clog2(NB):1)-1:0]    dbg_src,
  input logic [((NB>1)?$clog2(NB):1)-1:0]    dbg_tgt,
  input logic                                rpt_en_q,
  input logic [NB-1:0]                       perr_v
);
  assert_gnt_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid & ~req_valid) == '0);

  assert_gnt_not_on_perr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid & perr_v) == '0);

  assert_perr_raises_glob_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_v != '0) |=> stop_glob);

  assert_silent_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rpt_en_q && !stop_clr) |=> $stable(stop_brd));

  assert_brd_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_brd != '0 && !stop_clr) |=> ((stop_brd & $past(stop_brd)) == $past(stop_brd)));

  assert_glob_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_glob && !stop_clr) |=> stop_glob);

  assert_dbg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_valid && !stop_clr) |=> (dbg_valid && $stable(dbg_src) && $stable(dbg_tgt)));
endmodule

bind xdom_filter xdom_filter_chk #(.NB(NB)) chk_i (.*);

// File: tb/xdom_filter_tb_top.sv
module xdom_filter_tb_top;
  localparam int NB  = 6;
  localparam int IDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mask_we = 1'b0, cfg_ctl_we = 1'b0, cfg_rpt_en = 1'b0, stop_clr = 1'b0;
  logic [IDW-1:0] cfg_mask_sel = '0;
  logic [NB-1:0]  cfg_mask_data = '0;
  logic [NB-1:0]  req_valid = '0, req_par = '0;
  logic [NB*IDW-1:0] req_src = '0, req_tgt = '0;
  logic [NB-1:0]  gnt_valid, stop_brd;
  logic           stop_glob, dbg_valid;
  logic [IDW-1:0] dbg_src, dbg_tgt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xdom_filter #(.NB(NB)) dut_i (.*);

  // {src[2:0], tgt[2:0], expected grant}; domains {0,1,2} {3,4} {5}
  localparam logic [6:0] VEC [10] = '{
    {3'd0, 3'd2, 1'b1}, {3'd2, 3'd0, 1'b1}, {3'd1, 3'd1, 1'b1},
    {3'd0, 3'd3, 1'b0}, {3'd3, 3'd4, 1'b1}, {3'd4, 3'd0, 1'b0},
    {3'd5, 3'd5, 1'b1}, {3'd5, 3'd4, 1'b0}, {3'd0, 3'd6, 1'b0},
    {3'd7, 3'd0, 1'b0}};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic lane(input int ln, input int s, input int t, input bit bad);
    req_valid[ln] = 1'b1;
    req_src[ln*IDW +: IDW] = IDW'(s);
    req_tgt[ln*IDW +: IDW] = IDW'(t);
    req_par[ln] = (^{1'b1, IDW'(s), IDW'(t)}) ^ bad;
  endtask

  task automatic idle();
    req_valid = '0; cfg_mask_we = 1'b0; cfg_ctl_we = 1'b0; stop_clr = 1'b0;
  endtask

  task automatic wmask(input int b, input logic [NB-1:0] m);
    @(negedge clk);
    cfg_mask_we = 1'b1; cfg_mask_sel = IDW'(b); cfg_mask_data = m;
    @(negedge clk);
    cfg_mask_we = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    idle(); stop_clr = 1'b1;
    @(negedge clk);
    stop_clr = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(gnt_valid == 0 && stop_brd == 0 && !stop_glob && !dbg_valid, "reset R2",
          {gnt_valid, stop_brd, stop_glob, dbg_valid}, 0);

    // R2: reset masks hold only self
    lane(0, 0, 0, 0); lane(1, 0, 1, 0); #1;
    check(gnt_valid[1:0] == 2'b01, "R2 reset self-only", gnt_valid, 1);
    @(negedge clk);
    check(stop_brd == 0 && !dbg_valid, "R3 reset report off", stop_brd, 0);
    idle();

    wmask(0, 6'b000111); wmask(1, 6'b000111); wmask(2, 6'b000111);
    wmask(3, 6'b011000); wmask(4, 6'b011000);

    // R1 table walk, lane 0, reporting disabled
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      lane(0, int'(VEC[k][6:4]), int'(VEC[k][3:1]), 0); #1;
      check(gnt_valid[0] == VEC[k][0], $sformatf("R1 vec %0d", k), gnt_valid, VEC[k][0]);
      @(negedge clk);
      check(stop_brd == 0 && !stop_glob, $sformatf("R3 vec %0d no stop", k), stop_brd, 0);
      idle();
    end

    // R2: out-of-range select ignored
    wmask(6, 6'b111111);
    @(negedge clk); lane(0, 5, 0, 0); #1;
    check(!gnt_valid[0], "R2 sel out of range", gnt_valid, 0);
    idle();
    // R2: self bit forced
    wmask(5, 6'b000000);
    @(negedge clk); lane(0, 5, 5, 0); #1;
    check(gnt_valid[0], "R2 self forced", gnt_valid, 1);
    idle();
    // R2: write takes effect next cycle
    @(negedge clk);
    cfg_mask_we = 1'b1; cfg_mask_sel = 3'd5; cfg_mask_data = 6'b010000;
    lane(0, 5, 4, 0); #1;
    check(!gnt_valid[0], "R2 old mask same cycle", gnt_valid, 0);
    @(negedge clk); cfg_mask_we = 1'b0; #1;
    check(gnt_valid[0], "R2 new mask next cycle", gnt_valid, 1);
    idle();
    wmask(5, 6'b000000);

    // R4/R7: enable reporting
    @(negedge clk); cfg_ctl_we = 1'b1; cfg_rpt_en = 1'b1;
    @(negedge clk); idle();
    lane(1, 3, 0, 0);
    @(negedge clk);
    check(stop_brd == 6'b011000 && !stop_glob, "R4 source domain stop", stop_brd, 6'b011000);
    check(dbg_valid && dbg_src == 3 && dbg_tgt == 0, "R7 first capture", {dbg_src, dbg_tgt}, {3'd3, 3'd0});
    idle(); lane(0, 0, 5, 0);
    @(negedge clk);
    check(stop_brd == 6'b011111, "R6 sticky OR", stop_brd, 6'b011111);
    check(dbg_src == 3 && dbg_tgt == 0, "R7 capture held", {dbg_src, dbg_tgt}, {3'd3, 3'd0});
    clear();
    check(stop_brd == 0 && !dbg_valid, "R6 clear", {stop_brd, dbg_valid}, 0);

    // R8/R7: several lanes at once
    @(negedge clk);
    lane(2, 4, 1, 0); lane(4, 0, 3, 0); lane(3, 1, 2, 0); #1;
    check(gnt_valid == 6'b001000, "R8 independent grants", gnt_valid, 6'b001000);
    @(negedge clk);
    check(stop_brd == 6'b011111, "R8 stops ORed", stop_brd, 6'b011111);
    check(dbg_src == 4 && dbg_tgt == 1, "R7 lowest lane wins", {dbg_src, dbg_tgt}, {3'd4, 3'd1});
    idle();

    // R6: clear and new event same cycle
    @(negedge clk); stop_clr = 1'b1; lane(0, 5, 0, 0);
    @(negedge clk);
    check(stop_brd == 6'b100000, "R6 event wins over clear", stop_brd, 6'b100000);
    check(dbg_valid && dbg_src == 5, "R7 recapture on clear", dbg_src, 5);
    clear();

    // R5: parity error
    @(negedge clk); lane(1, 0, 1, 1); #1;
    check(!gnt_valid[1], "R5 parity blocks", gnt_valid, 0);
    @(negedge clk);
    check(stop_glob && stop_brd == 0, "R5 global stop", {stop_glob, stop_brd}, 7'b1000000);
    check(dbg_src == 0 && dbg_tgt == 1, "R7 parity capture", {dbg_src, dbg_tgt}, {3'd0, 3'd1});
    clear();
    check(!stop_glob, "R6 glob cleared", stop_glob, 0);
    // R5: parity ignored while invalid
    @(negedge clk); req_valid = '0; req_par = 6'b111111;
    @(negedge clk);
    check(!stop_glob && !dbg_valid, "R5 invalid unchecked", stop_glob, 0);

    // R4: out-of-range source silent
    idle(); lane(0, 7, 0, 0);
    @(negedge clk);
    check(stop_brd == 0 && !dbg_valid, "R4 bad source silent", {stop_brd, dbg_valid}, 0);

    // R3: disable reporting again
    idle(); cfg_ctl_we = 1'b1; cfg_rpt_en = 1'b0;
    @(negedge clk); idle(); lane(0, 0, 3, 0);
    @(negedge clk);
    check(stop_brd == 0 && !dbg_valid, "R3 disabled silent", {stop_brd, dbg_valid}, 0);
    idle();

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule